// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block keeps a bank of hardware event counters behind a small 64-bit register port. Each counter slice holds one counter per event code for each of two channels: channel 0 counts read-side events and channel 1 counts write-side events. Event sources raise single-cycle pulses on `evt_pulse`. Software picks one event code and one channel by writing the control register. Each slice then shows that counter in its own readback register, with the selected code echoed in the top nibble. Software polls until the echoed code equals the one it wrote, and only then trusts the count. The full total for an event is the sum of the slice readbacks.

The control register also holds a bank-wide freeze bit and a self-clearing clear bit. The register port is a plain single-cycle write strobe plus a read strobe, and read data returns one cycle later. The block carries no streaming data, so no valid/ready pair and no back-pressure exists anywhere. `COUNT_W` must not exceed 60 and `NUM_EVT` must not exceed 16.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter is zero, the control register reads 0, both readback registers read 0 (tag 0, count 0), and `reg_rvalid` is low.
- R2: A read strobe in one cycle raises `reg_rvalid` in the next cycle, with `reg_rdata` holding the register at `reg_addr`: 0x08 is the control register, and 0x10 and 0x18 are the readback registers of slices 0 and 1. Any other address reads 0.
- R3: Each pulse on `evt_pulse[s*2*NUM_EVT + c*NUM_EVT + e]` adds one to the counter of slice s, channel c (0 = read, 1 = write), event code e in the same clock edge.
- R4: Control register fields: bit 8 = freeze, bits 19:16 = event code, bit 20 = channel. Every other bit reads 0, and writing it has no effect. Bit 0 always reads 0.
- R5: A readback register holds the event code in bits 63:60 and the count in bits COUNT_W-1:0, with zeros between. After a control write at edge E, both fields change together at edge E+1 and take the new selection. The count is the counter's value before that edge.
- R6: When the selected code is 0xB to 0xF (no counter exists), the readback tag still echoes the code and the count reads 0.
- R7: While the stored freeze bit is 1, no counter changes except through a clear.
- R8: Writing the control register with bit 0 set zeroes every counter at that edge. This takes priority over pulses in the same cycle and applies even while frozen.
- R9: Counters wrap modulo 2^COUNT_W with no saturation.
- R10: Writes to the readback addresses or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | High one cycle after a read strobe |
| evt_pulse | input | NUM_SLICE*2*NUM_EVT | Event pulses, one per slice, channel and code |

## Verification
Each result has a fixed delay. A counter moves at the edge where its pulse is sampled. A control write changes the stored fields at its own edge and the readback registers one edge later. Read data appears one edge after the strobe, so a readback value seen on the port trails the control write by two edges. The bench drives every input at the falling edge and steps a behavioural model through one rising edge, taking all of the model's old state first. It then compares `reg_rvalid` and `reg_rdata` at the next falling edge. Because of this, each check lands in the exact cycle where the result is due, and the poll-for-tag window is covered cycle by cycle.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int DATA_W  = 64;
  localparam int TAG_W   = 4;
  localparam int TAG_LSB = 60;

  // register map (byte offsets)
  localparam logic [7:0] CTRL_OFS = 8'h08;
  localparam logic [7:0] RB_BASE  = 8'h10;
  localparam int         RB_STEP  = 8;

  // control field positions
  localparam int CLR_BIT  = 0;
  localparam int FRZ_BIT  = 8;
  localparam int EVT_LSB  = 16;
  localparam int CHAN_BIT = 20;

  localparam logic [DATA_W-1:0] CTRL_RD_MASK = 64'h0000_0000_001F_0100;

  typedef struct packed {
    logic             chan;
    logic [TAG_W-1:0] evt;
    logic             frz;
  } ctrl_t;
endpackage

// File: rtl/ecb_ctrl_reg.sv
module ecb_ctrl_reg
  import ecb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              clr_pulse,
  output logic [DATA_W-1:0] ctrl_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_hit) begin
      ctrl_q.chan <= wdata[CHAN_BIT];
      ctrl_q.evt  <= wdata[EVT_LSB +: TAG_W];
      ctrl_q.frz  <= wdata[FRZ_BIT];
    end
  end

  // clear is never stored: it acts on the write edge only
  assign clr_pulse = wr_hit & wdata[CLR_BIT];

  always_comb begin
    ctrl_rd                    = '0;
    ctrl_rd[CHAN_BIT]          = ctrl_q.chan;
    ctrl_rd[EVT_LSB +: TAG_W]  = ctrl_q.evt;
    ctrl_rd[FRZ_BIT]           = ctrl_q.frz;
  end
endmodule

// File: rtl/ecb_cnt_slice.sv
module ecb_cnt_slice #(
  parameter int NUM_EVT = 11,
  parameter int COUNT_W = 48
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           frz,
  input  logic [2*NUM_EVT-1:0]           evt,
  output logic [2*NUM_EVT*COUNT_W-1:0]   cnt_flat
);
  localparam int NCNT = 2 * NUM_EVT;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [COUNT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                c_q <= '0;
      else if (clr)              c_q <= '0;
      else if (!frz && evt[i])   c_q <= c_q + COUNT_W'(1);
    end
    assign cnt_flat[i*COUNT_W +: COUNT_W] = c_q;
  end
endmodule

// File: rtl/ecb_readback.sv
module ecb_readback
  import ecb_pkg::*;
#(
  parameter int NUM_SLICE = 2,
  parameter int NUM_EVT   = 11,
  parameter int COUNT_W   = 48,
  parameter int ADDR_W    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_SLICE*2*NUM_EVT*COUNT_W-1:0] cnt_all,
  input  ctrl_t                                  ctrl_q,
  input  logic [DATA_W-1:0]                      ctrl_rd,
  input  logic                                   rd,
  input  logic [ADDR_W-1:0]                      addr,
  output logic [DATA_W-1:0]                      rdata,
  output logic                                   rvalid,
  output logic [NUM_SLICE*TAG_W-1:0]             rb_tag
);
  localparam int PER = 2 * NUM_EVT;

  logic                evt_ok;
  int                  sel_idx;
  logic [COUNT_W-1:0]  pick  [NUM_SLICE];
  logic [DATA_W-1:0]   rb_q  [NUM_SLICE];
  logic [DATA_W-1:0]   mux_val;

  function automatic logic [DATA_W-1:0] pack_rb(input logic [TAG_W-1:0] tag,
                                                input logic [COUNT_W-1:0] c);
    logic [DATA_W-1:0] w;
    w                      = '0;
    w[TAG_LSB +: TAG_W]    = tag;
    w[COUNT_W-1:0]         = c;
    return w;
  endfunction

  always_comb begin
    evt_ok  = (int'(ctrl_q.evt) < NUM_EVT);
    sel_idx = evt_ok ? (int'(ctrl_q.chan) * NUM_EVT + int'(ctrl_q.evt)) : 0;
  end

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_rb
    always_comb begin
      pick[s] = evt_ok ? cnt_all[(s*PER + sel_idx)*COUNT_W +: COUNT_W] : '0;
    end
    // tag and count are captured by the same register: they move together
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rb_q[s] <= '0;
      else        rb_q[s] <= pack_rb(ctrl_q.evt, pick[s]);
    end
    assign rb_tag[s*TAG_W +: TAG_W] = rb_q[s][TAG_LSB +: TAG_W];
  end

  always_comb begin
    mux_val = '0;
    if (addr == ADDR_W'(CTRL_OFS)) mux_val = ctrl_rd;
    for (int s = 0; s < NUM_SLICE; s++) begin
      if (addr == ADDR_W'(int'(RB_BASE) + RB_STEP * s)) mux_val = rb_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? mux_val : '0;
    end
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_SLICE = 2,
  parameter int NUM_EVT   = 11,
  parameter int COUNT_W   = 48,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          reg_rvalid,
  input  logic [NUM_SLICE*2*NUM_EVT-1:0] evt_pulse
);
  localparam int PER        = 2 * NUM_EVT;
  localparam int SLICE_BITS = PER * COUNT_W;
  localparam int TOTAL_BITS = NUM_SLICE * SLICE_BITS;

  logic                          wr_ctrl_hit;
  ctrl_t                         ctrl_q;
  logic                          clr_pulse;
  logic [DATA_W-1:0]             ctrl_rd;
  logic [TOTAL_BITS-1:0]         cnt_all;
  logic [NUM_SLICE*TAG_W-1:0]    rb_tag;

  assign wr_ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));

  ecb_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_ctrl_hit),
    .wdata     (reg_wdata),
    .ctrl_q    (ctrl_q),
    .clr_pulse (clr_pulse),
    .ctrl_rd   (ctrl_rd)
  );

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    ecb_cnt_slice #(.NUM_EVT(NUM_EVT), .COUNT_W(COUNT_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_pulse),
      .frz      (ctrl_q.frz),
      .evt      (evt_pulse[s*PER +: PER]),
      .cnt_flat (cnt_all[s*SLICE_BITS +: SLICE_BITS])
    );
  end

  ecb_readback #(
    .NUM_SLICE (NUM_SLICE),
    .NUM_EVT   (NUM_EVT),
    .COUNT_W   (COUNT_W),
    .ADDR_W    (ADDR_W)
  ) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_all (cnt_all),
    .ctrl_q  (ctrl_q),
    .ctrl_rd (ctrl_rd),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .rdata   (reg_rdata),
    .rvalid  (reg_rvalid),
    .rb_tag  (rb_tag)
  );
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk
  import ecb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_BITS  = 8,
  parameter int NUM_SLICE = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       reg_rvalid,
  input logic [CNT_BITS-1:0]        cnt_all,
  input logic                       frz,
  input logic                       clr_pulse,
  input logic [NUM_SLICE*TAG_W-1:0] rb_tag
);
  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R4
  ctrl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(CTRL_OFS)) |=> ((reg_rdata & ~CTRL_RD_MASK) == '0));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !clr_pulse) |=> $stable(cnt_all));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_all == '0));

  // R5
  tag_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_OFS)) ##1 !(reg_wr && reg_addr == ADDR_W'(CTRL_OFS))
      |-> ##1 (rb_tag[TAG_W-1:0] == $past(reg_wdata[EVT_LSB +: TAG_W], 2)));
endmodule

bind evt_counter_bank ecb_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_BITS  (TOTAL_BITS),
  .NUM_SLICE (NUM_SLICE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .cnt_all    (cnt_all),
  .frz        (ctrl_q.frz),
  .clr_pulse  (clr_pulse),
  .rb_tag     (rb_tag)
);

// File: tb/evt_counter_bank_tb_top.sv
module evt_counter_bank_tb_top;
  localparam int NS  = 2;
  localparam int NE  = 11;
  localparam int CW  = 8;
  localparam int NEV = NS * 2 * NE;
  localparam int CMOD = 1 << CW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           reg_wr, reg_rd;
  logic [7:0]     reg_addr;
  logic [63:0]    reg_wdata;
  logic [63:0]    reg_rdata;
  logic           reg_rvalid;
  logic [NEV-1:0] evt_pulse;

  always #5 clk = ~clk;

  evt_counter_bank #(.NUM_SLICE(NS), .NUM_EVT(NE), .COUNT_W(CW), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .evt_pulse(evt_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_req = "R3";

  // behavioural model
  int          m_cnt [NS][2][NE];
  bit          m_frz, m_chan;
  bit [3:0]    m_evt;
  bit [63:0]   m_rb [NS];
  bit [63:0]   m_rdata;
  bit          m_rvalid;
  bit [7:0]    m_last_a;

  function automatic void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic bit [63:0] ctrl_val();
    bit [63:0] v = '0;
    v[20] = m_chan; v[19:16] = m_evt; v[8] = m_frz;
    return v;
  endfunction

  function automatic void model_reset();
    foreach (m_cnt[s, c, k]) m_cnt[s][c][k] = 0;
    m_frz = 0; m_chan = 0; m_evt = 0;
    foreach (m_rb[s]) m_rb[s] = '0;
    m_rdata = '0; m_rvalid = 0; m_last_a = '0;
  endfunction

  function automatic void model_edge(bit wr, bit rd, bit [7:0] a, bit [63:0] d, bit [NEV-1:0] e);
    bit clr;
    m_rvalid = rd;
    if (rd) begin
      m_last_a = a;
      if (a == 8'h08)      m_rdata = ctrl_val();
      else if (a == 8'h10) m_rdata = m_rb[0];
      else if (a == 8'h18) m_rdata = m_rb[1];
      else                 m_rdata = '0;
    end
    for (int s = 0; s < NS; s++) begin
      int c = (m_evt < NE) ? m_cnt[s][m_chan][m_evt] : 0;
      m_rb[s] = (64'(m_evt) << 60) | 64'(c);
    end
    clr = wr && a == 8'h08 && d[0];
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < NE; k++) begin
          if (clr) m_cnt[s][c][k] = 0;
          else if (!m_frz && e[s*2*NE + c*NE + k]) m_cnt[s][c][k] = (m_cnt[s][c][k] + 1) % CMOD;
        end
    if (wr && a == 8'h08) begin
      m_frz = d[8]; m_evt = d[19:16]; m_chan = d[20];
    end
  endfunction

  task automatic step(bit wr, bit rd, bit [7:0] a, bit [63:0] d, bit [NEV-1:0] e);
    string at;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(posedge clk);
    model_edge(wr, rd, a, d, e);
    @(negedge clk);
    chk(reg_rvalid === m_rvalid, "R2 rvalid", 64'(reg_rvalid), 64'(m_rvalid));
    if (m_rvalid) begin
      if (m_last_a == 8'h08)                          at = "R4 ctrl";
      else if (m_last_a == 8'h10 || m_last_a == 8'h18) at = "R3 R5 readback";
      else                                             at = "R2 unmapped";
      chk(reg_rdata === m_rdata, {cur_req, " ", at}, reg_rdata, m_rdata);
    end
  endtask

  function automatic bit [NEV-1:0] mk_ev(int dens);
    bit [63:0] r1 = {$urandom, $urandom};
    bit [63:0] r2 = {$urandom, $urandom};
    case (dens)
      0: return '0;
      1: return NEV'(r1 & r2);
      2: return NEV'(r1);
      default: return '1;
    endcase
  endfunction

  function automatic bit [7:0] pick_addr();
    case ($urandom % 5)
      0: return 8'h08;
      1, 2: return 8'h10;
      3: return 8'h18;
      default: return 8'h20;
    endcase
  endfunction

  task automatic run(int n, int dens);
    for (int i = 0; i < n; i++) step(0, ($urandom % 4) != 0, pick_addr(), '0, mk_ev(dens));
  endtask

  task automatic wr_ctrl(bit [63:0] d, int dens);
    step(1, 0, 8'h08, d, mk_ev(dens));
  endtask

  function automatic bit [63:0] sel(bit chan, bit [3:0] code, bit frz);
    bit [63:0] v = '0;
    v[20] = chan; v[19:16] = code; v[8] = frz;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%016h expected 0x%016h", 64'(0), 64'(1));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; evt_pulse = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(reg_rvalid === 1'b0, "R1 rvalid", 64'(reg_rvalid), 64'(0));
    chk(reg_rdata === '0, "R1 rdata", reg_rdata, 64'(0));
    cur_req = "R1";
    step(0, 1, 8'h08, '0, '0);
    step(0, 1, 8'h10, '0, '0);
    step(0, 1, 8'h18, '0, '0);

    // R3: counting on event 0, read channel
    cur_req = "R3";
    run(150, 2);
    run(50, 1);

    // R5 R6: sweep every code on both channels, poll across the tag change
    cur_req = "R5 R6";
    for (int ch = 0; ch < 2; ch++)
      for (int code = 0; code < 16; code++) begin
        wr_ctrl(sel(ch[0], code[3:0], 0), 2);
        step(0, 1, 8'h10, '0, mk_ev(2));
        step(0, 1, 8'h18, '0, mk_ev(2));
        step(0, 1, 8'h10, '0, mk_ev(2));
        run(10, 2);
      end
    // back-to-back control writes
    wr_ctrl(sel(1, 4'h5, 0), 2);
    wr_ctrl(sel(0, 4'hA, 0), 2);
    run(6, 2);

    // R7: freeze
    cur_req = "R7";
    wr_ctrl(sel(0, 4'h1, 1), 3);
    run(60, 3);
    wr_ctrl(sel(1, 4'h3, 1), 3);
    run(30, 3);
    wr_ctrl(sel(1, 4'h3, 0), 3);
    run(30, 2);

    // R8: clear with pulses present, then clear while frozen
    cur_req = "R8";
    wr_ctrl(sel(0, 4'h2, 0) | 64'h1, 3);
    run(20, 1);
    wr_ctrl(sel(0, 4'h2, 1), 3);
    wr_ctrl(sel(0, 4'h2, 1) | 64'h1, 3);
    run(10, 3);
    wr_ctrl(sel(0, 4'h0, 0), 0);

    // R4: undefined bits ignored, clear bit reads 0
    cur_req = "R4";
    wr_ctrl(64'hFFFF_FFFF_FFFF_FFFE, 0);
    step(0, 1, 8'h08, '0, '0);
    wr_ctrl(64'hFFFF_FFFF_FFE0_FEFF, 0);
    step(0, 1, 8'h08, '0, '0);
    wr_ctrl(64'hFFFF_FFFF_FFFF_FFFF, 2);
    step(0, 1, 8'h08, '0, '0);
    wr_ctrl(sel(0, 4'h7, 0), 0);

    // R9: wrap with dense pulses
    cur_req = "R9";
    run(600, 3);
    wr_ctrl(sel(1, 4'h9, 0), 3);
    run(300, 3);

    // R10: writes elsewhere ignored
    cur_req = "R10";
    for (int i = 0; i < 20; i++) begin
      bit [7:0] a = (i % 3 == 0) ? 8'h10 : (i % 3 == 1) ? 8'h18 : 8'h30;
      step(1, 0, a, {$urandom, $urandom}, mk_ev(1));
      step(0, 1, pick_addr(), '0, mk_ev(1));
    end
    step(0, 1, 8'h08, '0, '0);
    step(0, 1, 8'h0C, '0, '0);

    cur_req = "R3";
    run(100, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule